// File: doc/BRIEF.md
# Flash Array Ready/Busy and Hardware Reset Controller

This block follows the operating state of a flash array and reports it on a single active-low ready/busy line. The line is open drain: it either pulls low or lets go. Several arrays can therefore share one wire, and the shared wire reads low while any of them is busy. The block accepts program, erase, erase-suspend and resume requests, and it takes a completion pulse from the operation engine. It also filters a hardware reset pin and qualifies a high-voltage level on that pin that lifts block protection for as long as the level is held.

The reset pin arrives as a two-bit level code. A reset is recognised only after the pin has been low for a minimum number of cycles. What happens next depends on the state the array was in at that moment:

- **Idle or recovering:** the array stays reported as ready and waits for the pin to rise. It then accepts commands again after a short recovery count.
- **Program, erase or erase suspend:** the running operation is aborted and its data is flagged as corrupt. The line is held low for a fixed long count, and the line rising marks the end of the reset.

Each of these counts is set by a parameter.

Top module: `fsc_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, the line is released and `cmd_ack_o`, `abort_o` and `corrupt_o` are 0. `prot_eff_o` resets to all ones.
- R2: In the idle state, with the pin not low, a program request (which wins over erase) or an erase request to an unprotected block gives a one-cycle `cmd_ack_o` on the next edge. The line is pulled low from that edge until the edge that samples `op_done`.
- R3: A program or erase request to a block whose bit in `prot_eff_o` is 1 is rejected: there is no acknowledge and the line stays released.
- R4: While busy, the only command accepted is suspend during an erase. It is acknowledged and releases the line. Program, erase and resume requests while busy, and suspend during a program, get no acknowledge. In suspend, only resume is accepted.
- R5: Resume from suspend is acknowledged and pulls the line low until `op_done`.
- R6: `pin_lvl` encodes 0 = low, 1 = normal high, 2 = ramping toward the unprotect level, 3 = unprotect level. A low pulse of fewer than `MIN_LOW` cycles has no effect on state, line or `abort_o`.
- R7: A reset recognised while idle keeps the line released. Commands are rejected while the pin is low. After the pin rises, a request held high is first acknowledged `RECOV_CYC`+2 edges after the first edge with the pin not low.
- R8: A reset recognised during program, erase or suspend gives a one-cycle `abort_o` and sets `corrupt_o`. The line is held low for exactly `HRST_CYC` cycles and then released. The next accepted command clears `corrupt_o`.
- R9: Reset recognition has priority over `op_done` and over a suspend request in the same cycle: the abort still happens and no acknowledge is given.
- R10: After the pin has spent at least `RAMP_MIN` cycles at code 2 and then reaches code 3, `prot_eff_o` becomes all zeros from the next edge, and protected blocks accept commands. Once the pin leaves code 3, `prot_eff_o` follows `prot_i` again.
- R11: A ramp of fewer than `RAMP_MIN` cycles before code 3 does not lift protection.
- R12: `rb_od` only ever drives 0 or high impedance. With a pull-up and several instances on one wire, the wire is low while any instance is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_lvl | input | 2 | Reset pin level code (see R6) |
| prot_i | input | NBLK | Stored per-block protection bits |
| blk_i | input | $clog2(NBLK) | Target block of a program or erase request |
| req_prog | input | 1 | Program request |
| req_erase | input | 1 | Erase request |
| req_susp | input | 1 | Erase suspend request |
| req_resume | input | 1 | Resume request |
| op_done | input | 1 | Operation engine completion pulse |
| rb_od | output | 1 | Open-drain ready/busy, 0 = busy, Z = ready |
| cmd_ack_o | output | 1 | One-cycle command accepted pulse |
| abort_o | output | 1 | One-cycle abort to the operation engine |
| corrupt_o | output | 1 | Data of the aborted operation is invalid |
| prot_eff_o | output | NBLK | Effective protection mask |

## Verification
The end of the reset pin's minimum low window can land on the same edge as an engine completion pulse, or on the same edge as a suspend request. The bench sets up each collision deliberately: it drops the pin `MIN_LOW` cycles early and raises `op_done` or `req_susp` only for the final low cycle. A correct outcome is a single abort, no acknowledge, and a line held low for the full long reset period rather than released.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PROG,
    S_ERASE,
    S_SUSP,
    S_HRST,
    S_PLOW,
    S_RECOV
  } fsc_state_e;

  localparam logic [1:0] PIN_LOW  = 2'd0;
  localparam logic [1:0] PIN_HIGH = 2'd1;
  localparam logic [1:0] PIN_RAMP = 2'd2;
  localparam logic [1:0] PIN_HV   = 2'd3;

  function automatic logic st_busy(input fsc_state_e s);
    return (s == S_PROG) || (s == S_ERASE) || (s == S_HRST);
  endfunction

  function automatic logic st_running(input fsc_state_e s);
    return (s == S_PROG) || (s == S_ERASE) || (s == S_SUSP);
  endfunction

endpackage

// File: rtl/fsc_lowfilt.sv
module fsc_lowfilt #(
  parameter int MIN_LOW = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_low,
  output logic hit
);
  localparam int LW = $clog2(MIN_LOW + 1);

  logic [LW-1:0] cnt_q;

  // Fires once, on the MIN_LOW-th consecutive low cycle.
  assign hit = pin_low && (cnt_q == LW'(MIN_LOW - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (!pin_low) begin
      cnt_q <= '0;
    end else if (cnt_q != LW'(MIN_LOW)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/fsc_unprot.sv
module fsc_unprot import fsc_pkg::*; #(
  parameter int NBLK     = 8,
  parameter int RAMP_MIN = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      pin_lvl,
  input  logic [NBLK-1:0] prot_i,
  output logic [NBLK-1:0] prot_eff,
  output logic            unp_o
);
  localparam int RW = $clog2(RAMP_MIN + 1);

  logic [RW-1:0] ramp_q;
  logic          unp_n;

  assign unp_n = (pin_lvl == PIN_HV) && (unp_o || (ramp_q == RW'(RAMP_MIN)));

  always_ff @(posedge clk) begin
    if (rst) begin
      ramp_q   <= '0;
      unp_o    <= 1'b0;
      prot_eff <= '1;
    end else begin
      case (pin_lvl)
        PIN_RAMP: if (ramp_q != RW'(RAMP_MIN)) ramp_q <= ramp_q + 1'b1;
        PIN_HV:   ramp_q <= ramp_q;
        default:  ramp_q <= '0;
      endcase
      unp_o    <= unp_n;
      prot_eff <= unp_n ? '0 : prot_i;
    end
  end
endmodule

// File: rtl/fsc_timer.sv
module fsc_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] val,
  output logic          expire
);
  logic [TW-1:0] cnt_q;

  assign expire = (cnt_q == TW'(1)) && !load;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/fsc_ctrl.sv
module fsc_ctrl import fsc_pkg::*; #(
  parameter int NBLK      = 8,
  parameter int MIN_LOW   = 8,
  parameter int RECOV_CYC = 16,
  parameter int HRST_CYC  = 64,
  parameter int RAMP_MIN  = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [1:0]              pin_lvl,
  input  logic [NBLK-1:0]         prot_i,
  input  logic [$clog2(NBLK)-1:0] blk_i,
  input  logic                    req_prog,
  input  logic                    req_erase,
  input  logic                    req_susp,
  input  logic                    req_resume,
  input  logic                    op_done,
  output wire                     rb_od,
  output logic                    cmd_ack_o,
  output logic                    abort_o,
  output logic                    corrupt_o,
  output logic [NBLK-1:0]         prot_eff_o
);
  localparam int TMAX = (HRST_CYC > RECOV_CYC) ? HRST_CYC : RECOV_CYC;
  localparam int TW   = $clog2(TMAX + 1);

  fsc_state_e    st_q, st_n;
  logic          busy_q;
  logic          rst_hit;
  logic          unp;
  logic          tmr_ld, tmr_exp;
  logic [TW-1:0] tmr_val;
  logic          ack_n, abort_n, corrupt_n;
  logic          tgt_ok, pin_is_low;

  assign pin_is_low = (pin_lvl == PIN_LOW);

  fsc_lowfilt #(.MIN_LOW(MIN_LOW)) u_filt (
    .clk     (clk),
    .rst     (rst),
    .pin_low (pin_is_low),
    .hit     (rst_hit)
  );

  fsc_unprot #(.NBLK(NBLK), .RAMP_MIN(RAMP_MIN)) u_unp (
    .clk      (clk),
    .rst      (rst),
    .pin_lvl  (pin_lvl),
    .prot_i   (prot_i),
    .prot_eff (prot_eff_o),
    .unp_o    (unp)
  );

  fsc_timer #(.TW(TW)) u_tmr (
    .clk    (clk),
    .rst    (rst),
    .load   (tmr_ld),
    .val    (tmr_val),
    .expire (tmr_exp)
  );

  assign tgt_ok = !prot_eff_o[blk_i];

  always_comb begin
    st_n      = st_q;
    ack_n     = 1'b0;
    abort_n   = 1'b0;
    corrupt_n = corrupt_o;
    tmr_ld    = 1'b0;
    tmr_val   = '0;
    if (rst_hit && st_running(st_q)) begin
      st_n      = S_HRST;
      abort_n   = 1'b1;
      corrupt_n = 1'b1;
      tmr_ld    = 1'b1;
      tmr_val   = TW'(HRST_CYC);
    end else if (rst_hit && (st_q == S_IDLE || st_q == S_RECOV)) begin
      st_n = S_PLOW;
    end else begin
      case (st_q)
        S_IDLE: begin
          if (!pin_is_low && tgt_ok) begin
            if (req_prog) begin
              st_n      = S_PROG;
              ack_n     = 1'b1;
              corrupt_n = 1'b0;
            end else if (req_erase) begin
              st_n      = S_ERASE;
              ack_n     = 1'b1;
              corrupt_n = 1'b0;
            end
          end
        end
        S_PROG: begin
          if (op_done) st_n = S_IDLE;
        end
        S_ERASE: begin
          if (op_done) begin
            st_n = S_IDLE;
          end else if (req_susp) begin
            st_n  = S_SUSP;
            ack_n = 1'b1;
          end
        end
        S_SUSP: begin
          if (req_resume) begin
            st_n  = S_ERASE;
            ack_n = 1'b1;
          end
        end
        S_HRST: begin
          if (tmr_exp) st_n = pin_is_low ? S_PLOW : S_IDLE;
        end
        S_PLOW: begin
          if (!pin_is_low) begin
            st_n    = S_RECOV;
            tmr_ld  = 1'b1;
            tmr_val = TW'(RECOV_CYC);
          end
        end
        S_RECOV: begin
          if (tmr_exp) st_n = S_IDLE;
        end
        default: st_n = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= S_IDLE;
      busy_q    <= 1'b0;
      cmd_ack_o <= 1'b0;
      abort_o   <= 1'b0;
      corrupt_o <= 1'b0;
    end else begin
      st_q      <= st_n;
      busy_q    <= st_busy(st_n);
      cmd_ack_o <= ack_n;
      abort_o   <= abort_n;
      corrupt_o <= corrupt_n;
    end
  end

  assign rb_od = busy_q ? 1'b0 : 1'bz;

endmodule

// File: rtl/fsc_chk.sv
module fsc_chk #(
  parameter int NBLK = 8
) (
  input logic            clk,
  input logic            rst,
  input logic [1:0]      pin_lvl,
  input logic [NBLK-1:0] prot_i,
  input logic [NBLK-1:0] prot_eff_o,
  input logic            req_susp,
  input logic            cmd_ack_o,
  input logic            abort_o,
  input logic            corrupt_o,
  input logic            busy_q
);

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!busy_q && !cmd_ack_o && !abort_o && !corrupt_o));

  p_abort_single_r8: assert property (@(posedge clk) disable iff (rst)
    abort_o |=> !abort_o);

  p_abort_busy_r8: assert property (@(posedge clk) disable iff (rst)
    abort_o |-> (busy_q && corrupt_o));

  p_release_ack_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd_ack_o && !busy_q) |-> ($past(busy_q) && $past(req_susp)));

  p_no_ack_on_abort_r9: assert property (@(posedge clk) disable iff (rst)
    !(cmd_ack_o && abort_o));

  p_prot_restore_r10: assert property (@(posedge clk) disable iff (rst)
    (pin_lvl != 2'd3) |=> (prot_eff_o == $past(prot_i)));

endmodule

bind fsc_ctrl fsc_chk #(.NBLK(NBLK)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .pin_lvl    (pin_lvl),
  .prot_i     (prot_i),
  .prot_eff_o (prot_eff_o),
  .req_susp   (req_susp),
  .cmd_ack_o  (cmd_ack_o),
  .abort_o    (abort_o),
  .corrupt_o  (corrupt_o),
  .busy_q     (busy_q)
);

// File: tb/sim_fsc_ctrl.sv
module sim_fsc_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam int ML = 4;
  localparam int RC = 5;
  localparam int HC = 12;
  localparam int RM = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    pin = 2'd1;
  logic [NB-1:0] prot = '0;
  logic [1:0]    blk = '0;
  logic          rp = 0, re = 0, rs = 0, rr = 0, dn = 0;
  logic          rp1 = 0, dn1 = 0;
  wire           rb_line;
  logic          ack0, abt0, cor0, ack1, abt1, cor1;
  logic [NB-1:0] pe0, pe1;

  int total = 0, bad = 0, n_ack = 0, n_abt = 0;
  bit finished = 0;

  pullup (rb_line);

  always #(CLK_PERIOD/2) clk = ~clk;

  fsc_ctrl #(.NBLK(NB), .MIN_LOW(ML), .RECOV_CYC(RC), .HRST_CYC(HC), .RAMP_MIN(RM)) u0 (
    .clk(clk), .rst(rst), .pin_lvl(pin), .prot_i(prot), .blk_i(blk),
    .req_prog(rp), .req_erase(re), .req_susp(rs), .req_resume(rr), .op_done(dn),
    .rb_od(rb_line), .cmd_ack_o(ack0), .abort_o(abt0), .corrupt_o(cor0), .prot_eff_o(pe0));

  fsc_ctrl #(.NBLK(NB), .MIN_LOW(ML), .RECOV_CYC(RC), .HRST_CYC(HC), .RAMP_MIN(RM)) u1 (
    .clk(clk), .rst(rst), .pin_lvl(2'd1), .prot_i({NB{1'b0}}), .blk_i(2'd0),
    .req_prog(rp1), .req_erase(1'b0), .req_susp(1'b0), .req_resume(1'b0), .op_done(dn1),
    .rb_od(rb_line), .cmd_ack_o(ack1), .abort_o(abt1), .corrupt_o(cor1), .prot_eff_o(pe1));

  function automatic int line();
    return (rb_line === 1'b0) ? 0 : 1;
  endfunction

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (ack0) n_ack++;
      if (abt0) n_abt++;
    end
  endtask

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic issue(input bit erase, input int b);
    blk = b[1:0];
    if (erase) re = 1; else rp = 1;
    step(1);
    re = 0; rp = 0;
  endtask

  task automatic finish_op();
    dn = 1; step(1); dn = 0;
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int a, b0, first;
    step(3);
    // R1 reset state
    chk(line() == 1, "R1 line", line(), 1);
    chk(!ack0 && !abt0 && !cor0, "R1 flags", {ack0, abt0, cor0}, 0);
    chk(pe0 == '1, "R1 prot_eff", pe0, 4'hF);
    rst = 0;
    step(2);

    // R2 program and erase accepted
    for (int e = 0; e < 2; e++) begin
      a = n_ack;
      issue(e[0], 1);
      chk(n_ack - a == 1 && line() == 0, "R2 accept", (n_ack - a) * 2 + line(), 2);
      step(3);
      chk(line() == 0, "R2 busy hold", line(), 0);
      finish_op();
      chk(line() == 1, "R2 done release", line(), 1);
    end

    // R3 protection sweep
    for (int pat = 0; pat < 16; pat++) begin
      for (int bb = 0; bb < NB; bb++) begin
        int ex;
        prot = pat[NB-1:0];
        step(1);
        a = n_ack;
        issue(((pat ^ bb) & 1) != 0, bb);
        ex = pat[bb] ? 0 : 1;
        chk(n_ack - a == ex, "R3 ack", n_ack - a, ex);
        chk(line() == 1 - ex, "R3 line", line(), 1 - ex);
        if (ex == 1) finish_op();
      end
    end
    prot = '0;
    step(1);

    // R4 busy rejection and erase suspend
    issue(1, 0);
    a = n_ack;
    rp = 1; step(1); rp = 0;
    re = 1; step(1); re = 0;
    rr = 1; step(1); rr = 0;
    chk(n_ack == a && line() == 0, "R4 reject while busy", n_ack - a, 0);
    rs = 1; step(1); rs = 0;
    chk(n_ack - a == 1 && line() == 1, "R4 suspend", (n_ack - a) * 2 + line(), 3);
    a = n_ack;
    rp = 1; step(1); rp = 0;
    chk(n_ack == a && line() == 1, "R4 reject in suspend", n_ack - a, 0);
    // R5 resume
    rr = 1; step(1); rr = 0;
    chk(n_ack - a == 1 && line() == 0, "R5 resume", (n_ack - a) * 2 + line(), 2);
    step(2);
    chk(line() == 0, "R5 busy", line(), 0);
    finish_op();
    chk(line() == 1, "R5 done", line(), 1);
    issue(0, 0);
    a = n_ack;
    rs = 1; step(1); rs = 0;
    chk(n_ack == a && line() == 0, "R4 suspend in program", n_ack - a, 0);
    finish_op();

    // R6 short pulses
    for (int n = 1; n < ML; n++) begin
      b0 = n_abt;
      pin = 0; step(n); pin = 1;
      a = n_ack;
      issue(0, 2);
      chk(n_ack - a == 1, "R6 idle short pulse", n_ack - a, 1);
      pin = 0; step(n); pin = 1;
      step(2);
      chk(line() == 0 && n_abt == b0, "R6 busy short pulse", line() + (n_abt - b0), 0);
      finish_op();
    end

    // R8 long reset from program, erase and suspend
    for (int v = 0; v < 3; v++) begin
      issue(v != 0, 3);
      if (v == 2) begin rs = 1; step(1); rs = 0; end
      b0 = n_abt;
      pin = 0; step(ML); pin = 1;
      chk(n_abt - b0 == 1, "R8 abort", n_abt - b0, 1);
      chk(cor0 == 1, "R8 corrupt", cor0, 1);
      step(HC - 1);
      chk(line() == 0, "R8 held low", line(), 0);
      step(1);
      chk(line() == 1, "R8 released", line(), 1);
      a = n_ack;
      issue(0, 0);
      chk(n_ack - a == 1 && cor0 == 0, "R8 clear corrupt", cor0, 0);
      finish_op();
    end

    // R7 reset while idle, recovery count
    b0 = n_abt;
    pin = 0; step(ML + 2);
    chk(line() == 1 && n_abt == b0, "R7 idle reset line", line(), 1);
    a = n_ack;
    rp = 1; step(1);
    chk(n_ack == a, "R7 reject while low", n_ack - a, 0);
    pin = 1;
    first = 0;
    for (int k = 1; k <= RC + 5; k++) begin
      step(1);
      if (ack0 && first == 0) begin first = k; rp = 0; end
    end
    rp = 0;
    chk(first == RC + 2, "R7 recovery", first, RC + 2);
    finish_op();

    // R9 collisions at the recognition edge
    issue(0, 1);
    b0 = n_abt;
    pin = 0; step(ML - 1); dn = 1; step(1); dn = 0; pin = 1;
    chk(n_abt - b0 == 1 && line() == 0, "R9 done vs reset", n_abt - b0, 1);
    step(HC);
    chk(line() == 1, "R9 long release", line(), 1);
    issue(1, 1);
    b0 = n_abt; a = n_ack;
    pin = 0; step(ML - 1); rs = 1; step(1); rs = 0; pin = 1;
    chk(n_abt - b0 == 1 && n_ack == a, "R9 suspend vs reset", n_ack - a, 0);
    step(HC);

    // R10 and R11 ramp sweep
    prot = '1;
    step(1);
    for (int n = 0; n <= RM + 1; n++) begin
      int ex;
      if (n > 0) begin pin = 2; step(n); end
      pin = 3; step(1);
      ex = (n >= RM) ? 1 : 0;
      chk(pe0 == (ex ? 4'h0 : 4'hF), n >= RM ? "R10 unprotect" : "R11 fast ramp", pe0, ex ? 0 : 15);
      a = n_ack;
      issue(0, n % NB);
      chk(n_ack - a == ex, "R10 protected accept", n_ack - a, ex);
      if (ex == 1) finish_op();
      pin = 1; step(1);
      chk(pe0 == 4'hF, "R10 restore", pe0, 15);
    end
    prot = '0;
    step(1);

    // R12 wired-AND
    rp1 = 1; step(1); rp1 = 0;
    chk(line() == 0, "R12 other busy", line(), 0);
    issue(0, 0);
    dn = 1; step(1); dn = 0;
    chk(line() == 0, "R12 still low", line(), 0);
    dn1 = 1; step(1); dn1 = 0;
    chk(line() == 1, "R12 released", line(), 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule